// File: doc/BRIEF.md
# Trigger Primitive Decompression Unit

This block expands the compressed energy codes of one calorimeter tower pair into linear energies. The pair is an electromagnetic (ECAL) tower and a hadronic (HCAL) tower. It also flags the pair as an electron candidate when the hadronic share is small enough. Each channel has its own conversion mode, chosen at run time:

- **Shift mode:** a floating-point style decode, where the mantissa is shifted left by the exponent.
- **Piecewise-linear mode:** four segments, each with its own slope and offset.

The segment slopes and offsets, the mode bits and the electron ratio sit in a small register bank. A single-cycle write port loads this bank while the data path keeps running. No rebuild of the logic is needed to change the conversion.

One tower pair is accepted per cycle when `in_valid` is high. Three register stages later the block presents the following, qualified by `out_valid`:

- both linear energies;
- their 18-bit sum;
- the electron flag.

Top module: `tpg_decomp`

## Requirements
- R1: In shift mode a channel's 8-bit code decodes as exponent = code[7:5] and mantissa = code[4:0], and the linear value equals mantissa shifted left by exponent.
- R2: In piecewise-linear mode, segment = code[7:6] and low = code[5:0], and the linear value equals offset[segment] + ((slope[segment] × low) >> 4).
- R3: A linear value that would exceed 131071 (17 bits all ones) is clamped to 131071.
- R4: `out_sum` equals `out_ecal + out_hcal` as an 18-bit value, with no loss.
- R5: `out_elec` is 1 exactly when HCAL × denominator < ECAL × numerator, using unsigned integer products. Both ratio terms are 8 bits.
- R6: A pair sampled at clock edge k appears on the outputs after edge k+2. `out_valid` is high for exactly those cycles.
- R7: When no pair is accepted, `out_ecal`, `out_hcal`, `out_sum` and `out_elec` keep their previous values.
- R8: The write address is {channel, select[1:0], segment[1:0]}. The channel bit selects ECAL (0) or HCAL (1). The select field is decoded as follows:
  - 0 writes that channel's segment slope from `wr_data[15:0]`.
  - 1 writes that channel's segment offset from `wr_data[16:0]`.
  - 2 writes the channel mode from `wr_data[0]` (1 = piecewise-linear).
  - 3 writes the ratio from `wr_data[7:0]`: the numerator on channel 0, the denominator on channel 1.
- R9: A write sampled on the same edge as a pair does not affect that pair. The next pair accepted uses the new setting. A write to one channel never changes the other channel's conversion.
- R10: Synchronous reset clears `out_valid` and all outputs to 0, puts both channels in shift mode with zero slopes and offsets, and sets numerator = denominator = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Tower pair present |
| in_ecal | input | 8 | Compressed ECAL code |
| in_hcal | input | 8 | Compressed HCAL code |
| wr_en | input | 1 | Parameter write strobe |
| wr_addr | input | 5 | Parameter address |
| wr_data | input | 17 | Parameter value |
| out_valid | output | 1 | Results valid |
| out_ecal | output | 17 | Linear ECAL energy |
| out_hcal | output | 17 | Linear HCAL energy |
| out_sum | output | 18 | ECAL + HCAL |
| out_elec | output | 1 | Electron candidate flag |

## Verification
Every result of a pair sampled at edge k is due after edge k+2, so all four outputs and `out_valid` are checked together in the cycle that follows. The bench keeps a three-entry queue of expected records. At each falling edge it compares the outputs with the oldest entry before pushing the pair it drives next. The expected record is computed from the parameter model as it stood before any write driven in the same cycle, which matches R9's ordering. Cycles with no valid pair are compared against the last valid results, so hold behaviour is checked at the same point.

// File: rtl/tpg_decomp.sv
module tpg_decomp #(
  parameter int CODE_W  = 8,
  parameter int EXP_W   = 3,
  parameter int SEG_W   = 2,
  parameter int LIN_W   = 17,
  parameter int SLOPE_W = 16,
  parameter int FRAC    = 4,
  parameter int RAT_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [CODE_W-1:0]    in_ecal,
  input  logic [CODE_W-1:0]    in_hcal,
  input  logic                 wr_en,
  input  logic [SEG_W+2:0]     wr_addr,
  input  logic [LIN_W-1:0]     wr_data,
  output logic                 out_valid,
  output logic [LIN_W-1:0]     out_ecal,
  output logic [LIN_W-1:0]     out_hcal,
  output logic [LIN_W:0]       out_sum,
  output logic                 out_elec
);
  localparam int MANT_W = CODE_W - EXP_W;
  localparam int LOW_W  = CODE_W - SEG_W;
  localparam int NSEG   = 1 << SEG_W;
  localparam int SH_W   = MANT_W + (1 << EXP_W) - 1;
  localparam int PW     = SLOPE_W + LOW_W;
  localparam int A0     = (PW > LIN_W) ? PW : LIN_W;
  localparam int ACC_W  = ((A0 > SH_W) ? A0 : SH_W) + 1;
  localparam int PROD_W = LIN_W + RAT_W;
  localparam logic [LIN_W-1:0] LIN_MAX = '1;

  logic                mode_q  [2];
  logic [SLOPE_W-1:0]  slope_q [2][NSEG];
  logic [LIN_W-1:0]    off_q   [2][NSEG];
  logic [RAT_W-1:0]    num_q, den_q;

  wire              wch  = wr_addr[SEG_W+2];
  wire [1:0]        wsel = wr_addr[SEG_W+1:SEG_W];
  wire [SEG_W-1:0]  wseg = wr_addr[SEG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        mode_q[c] <= 1'b0;
        for (int s = 0; s < NSEG; s++) begin
          slope_q[c][s] <= '0;
          off_q[c][s]   <= '0;
        end
      end
      num_q <= RAT_W'(1);
      den_q <= RAT_W'(1);
    end else if (wr_en) begin
      case (wsel)
        2'd0: slope_q[wch][wseg] <= wr_data[SLOPE_W-1:0];
        2'd1: off_q[wch][wseg]   <= wr_data;
        2'd2: mode_q[wch]        <= wr_data[0];
        default: begin
          if (wch) den_q <= wr_data[RAT_W-1:0];
          else     num_q <= wr_data[RAT_W-1:0];
        end
      endcase
    end
  end

  function automatic logic [LIN_W-1:0] conv(input logic m,
                                            input logic [CODE_W-1:0] c,
                                            input logic [SLOPE_W-1:0] sl,
                                            input logic [LIN_W-1:0] of);
    logic [ACC_W-1:0] sh, pw, r;
    logic [PW-1:0]    p;
    sh = ACC_W'(c[MANT_W-1:0]) << c[CODE_W-1:MANT_W];
    p  = PW'(sl) * PW'(c[LOW_W-1:0]);
    pw = ACC_W'(of) + ACC_W'(p >> FRAC);
    r  = m ? pw : sh;
    conv = (r > ACC_W'(LIN_MAX)) ? LIN_MAX : r[LIN_W-1:0];
  endfunction

  wire [SEG_W-1:0] eseg = in_ecal[CODE_W-1 -: SEG_W];
  wire [SEG_W-1:0] hseg = in_hcal[CODE_W-1 -: SEG_W];
  wire [LIN_W-1:0] e_lin = conv(mode_q[0], in_ecal, slope_q[0][eseg], off_q[0][eseg]);
  wire [LIN_W-1:0] h_lin = conv(mode_q[1], in_hcal, slope_q[1][hseg], off_q[1][hseg]);

  logic              s1_v, s2_v;
  logic [LIN_W-1:0]  s1_e, s1_h, s2_e, s2_h;
  logic [RAT_W-1:0]  s1_num, s1_den;
  logic [LIN_W:0]    s2_sum;
  logic [PROD_W-1:0] s2_hd, s2_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s2_v <= 1'b0; out_valid <= 1'b0;
      s1_e <= '0; s1_h <= '0; s1_num <= '0; s1_den <= '0;
      s2_e <= '0; s2_h <= '0; s2_sum <= '0; s2_hd <= '0; s2_en <= '0;
      out_ecal <= '0; out_hcal <= '0; out_sum <= '0; out_elec <= 1'b0;
    end else begin
      s1_v      <= in_valid;
      s2_v      <= s1_v;
      out_valid <= s2_v;
      if (in_valid) begin
        s1_e   <= e_lin;
        s1_h   <= h_lin;
        s1_num <= num_q;
        s1_den <= den_q;
      end
      if (s1_v) begin
        s2_e   <= s1_e;
        s2_h   <= s1_h;
        s2_sum <= (LIN_W+1)'(s1_e) + (LIN_W+1)'(s1_h);
        s2_hd  <= PROD_W'(s1_h) * PROD_W'(s1_den);
        s2_en  <= PROD_W'(s1_e) * PROD_W'(s1_num);
      end
      if (s2_v) begin
        out_ecal <= s2_e;
        out_hcal <= s2_h;
        out_sum  <= s2_sum;
        out_elec <= s2_hd < s2_en;
      end
    end
  end
endmodule

module tpg_decomp_chk #(
  parameter int LIN_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [LIN_W-1:0] out_ecal,
  input logic [LIN_W-1:0] out_hcal,
  input logic [LIN_W:0]   out_sum,
  input logic             out_elec
);
  a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##3 !out_valid);
  a_r7_hold_sum: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_sum) && $stable(out_elec));
  a_r4_sum_exact: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_sum == ((LIN_W+1)'(out_ecal) + (LIN_W+1)'(out_hcal)));
  a_r5_flag_needs_ecal: assert property (@(posedge clk) disable iff (rst)
    out_elec |-> out_ecal != '0);
endmodule

bind tpg_decomp tpg_decomp_chk #(.LIN_W(LIN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_ecal(out_ecal), .out_hcal(out_hcal), .out_sum(out_sum), .out_elec(out_elec)
);

// File: tb/sim_tpg_decomp.sv
module sim_tpg_decomp;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_ecal = '0, in_hcal = '0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [16:0] wr_data = '0;
  logic out_valid;
  logic [16:0] out_ecal, out_hcal;
  logic [17:0] out_sum;
  logic out_elec;

  tpg_decomp u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ecal(in_ecal), .in_hcal(in_hcal),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_ecal(out_ecal), .out_hcal(out_hcal),
    .out_sum(out_sum), .out_elec(out_elec)
  );

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int m_mode [2];
  int m_slope [2][4];
  int m_off [2][4];
  int m_num, m_den;

  bit pv [3];
  longint pe [3], ph [3];
  bit pf [3];
  string pte [3], pth [3];
  longint le, lh;
  bit lf;

  task automatic chk(string tag, string what, longint got, longint exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic longint ref_conv(int ch, int code, output bit sat);
    longint v;
    if (m_mode[ch] != 0)
      v = longint'(m_off[ch][code >> 6]) + ((longint'(m_slope[ch][code >> 6]) * (code & 63)) >> 4);
    else
      v = longint'(code & 31) << (code >> 5);
    sat = v > 131071;
    return sat ? 131071 : v;
  endfunction

  function automatic string auto_tag(int ch, bit sat);
    if (sat) return "R3";
    return (m_mode[ch] != 0) ? "R2" : "R1";
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_mode[c] = 0;
      for (int s = 0; s < 4; s++) begin m_slope[c][s] = 0; m_off[c][s] = 0; end
    end
    m_num = 1; m_den = 1;
    for (int i = 0; i < 3; i++) begin pv[i] = 0; pe[i] = 0; ph[i] = 0; pf[i] = 0; end
    le = 0; lh = 0; lf = 0;
  endtask

  task automatic step(bit v, int e, int h, bit we, int addr, int data, string tag);
    bit se, sh;
    longint xe, xh;
    string te, th;
    @(negedge clk);
    chk("R6", "out_valid", longint'(out_valid), longint'(pv[2]));
    if (pv[2]) begin
      le = pe[2]; lh = ph[2]; lf = pf[2]; te = pte[2]; th = pth[2];
      chk(te, "out_ecal", longint'(out_ecal), le);
      chk(th, "out_hcal", longint'(out_hcal), lh);
      chk("R4", "out_sum", longint'(out_sum), le + lh);
      chk("R5", "out_elec", longint'(out_elec), longint'(lf));
    end else begin
      chk("R7", "out_ecal hold", longint'(out_ecal), le);
      chk("R7", "out_hcal hold", longint'(out_hcal), lh);
      chk("R7", "out_sum hold", longint'(out_sum), le + lh);
      chk("R7", "out_elec hold", longint'(out_elec), longint'(lf));
    end
    for (int i = 2; i > 0; i--) begin
      pv[i] = pv[i-1]; pe[i] = pe[i-1]; ph[i] = ph[i-1]; pf[i] = pf[i-1];
      pte[i] = pte[i-1]; pth[i] = pth[i-1];
    end
    xe = ref_conv(0, e, se);
    xh = ref_conv(1, h, sh);
    pv[0] = v; pe[0] = xe; ph[0] = xh;
    pf[0] = (xh * m_den) < (xe * m_num);
    pte[0] = (tag != "") ? tag : auto_tag(0, se);
    pth[0] = (tag != "") ? tag : auto_tag(1, sh);
    in_valid = v; in_ecal = 8'(e); in_hcal = 8'(h);
    wr_en = we; wr_addr = 5'(addr); wr_data = 17'(data);
    if (we) begin
      case ((addr >> 2) & 3)
        0: m_slope[addr >> 4][addr & 3] = data & 16'hFFFF;
        1: m_off[addr >> 4][addr & 3] = data & 17'h1FFFF;
        2: m_mode[addr >> 4] = data & 1;
        default: if ((addr >> 4) != 0) m_den = data & 255; else m_num = data & 255;
      endcase
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10", "out_valid", longint'(out_valid), 0);
    chk("R10", "out_ecal", longint'(out_ecal), 0);
    chk("R10", "out_hcal", longint'(out_hcal), 0);
    chk("R10", "out_sum", longint'(out_sum), 0);
    // R10 default shift mode and unit ratio; R1 corners
    step(1, 8'hFF, 8'h00, 0, 0, 0, "R10");
    step(1, 8'h25, 8'h25, 0, 0, 0, "R1");
    step(1, 8'h01, 8'h02, 0, 0, 0, "R1");
    step(0, 8'h00, 8'h00, 0, 0, 0, "");
    // R9: same-edge write to ECAL mode does not affect this pair
    step(1, 8'hC4, 8'hC4, 1, 5'b0_10_00, 1, "R9");
    step(1, 8'hC4, 8'hC4, 0, 0, 0, "R9");
    // R8 slope/offset of ECAL segment 3, HCAL stays in shift mode
    step(1, 8'h10, 8'hE3, 1, 5'b0_00_11, 16'hFFFF, "R8");
    step(1, 8'hFF, 8'hE3, 1, 5'b0_01_11, 17'h1FFFF, "R8");
    step(1, 8'hC1, 8'hFF, 0, 0, 0, "R8");
    step(1, 8'h7F, 8'h7F, 1, 5'b0_00_01, 16'h0030, "R8");
    step(1, 8'h7F, 8'h40, 0, 0, 0, "R2");
    // R5 ratio: numerator 1, denominator 4
    step(1, 8'h7F, 8'h20, 1, 5'b1_11_00, 4, "R5");
    step(1, 8'h7F, 8'h20, 0, 0, 0, "R5");
    step(1, 8'h00, 8'h20, 0, 0, 0, "R5");
    for (int i = 0; i < 3000; i++) begin
      int a, d;
      a = int'($urandom % 32);
      d = int'($urandom % 131072);
      step(($urandom % 4) != 0, int'($urandom % 256), int'($urandom % 256),
           ($urandom % 10) == 0, a, d, "");
    end
    repeat (4) step(0, 0, 0, 0, 0, 0, "");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule